// File: doc/BRIEF.md
# NAND Flash Host Interface

This block lets a processor operate a raw NAND flash part through single-byte register accesses. A small configuration page, fixed at bus page 1 (address bits above the low byte equal to 1), holds an enable bit and a relocatable base address as wide as the bus address. When the window is enabled, a 256-byte window at that base exposes a data port, a control byte, a constant status byte, and an interrupt status and mask pair.

The control byte drives the flash command-latch, address-latch, chip-enable and write-protect pins directly. Its two-bit ECC field produces a one-cycle clear pulse or a read-select level for an ECC engine outside this block. Writes and reads on the data port produce same-cycle strobes on an 8-bit flash data bus. Every data write raises interrupt status bit 0. The single interrupt line is gated by bit 7 of the mask register, which acts as a global enable. Flash timing and ECC arithmetic belong to neighbouring logic.

Top module: `nand_host_if`

## Requirements
- R1: After reset the control byte is 0x00 (nf_cle=0, nf_ale=0, nf_ce_n=1, nf_wp=0). Status, mask, enable and base are all zero, and irq and ecc_clr are low.
- R2: A byte written to configuration offset 0x04 (bus address 0x104) enables the window through its bit 1. That offset reads back 0x02 when enabled and 0x00 when disabled.
- R3: The base address occupies configuration offsets 0x10 to 0x13, one byte each, least significant byte at 0x10. Each byte reads back as written.
- R4: Window accesses are decoded only when the enable bit is set and the bus address with its low 8 bits forced to zero equals the full base address. The configuration page takes priority over the window. Accesses outside the window have no effect and read 0x00.
- R5: Window offsets 0x00 to 0x03 form the data port. A write pulses nf_wr_stb in the same cycle with nf_dout equal to the written byte. A read pulses nf_rd_stb in the same cycle and returns nf_din.
- R6: The control byte at window offset 0x04 reads back as written. From the cycle after the write, nf_cle equals bit 0, nf_ale equals bit 1, nf_ce_n equals the inverse of bit 4, and nf_wp equals bit 7.
- R7: Bits 6:5 of the control byte are an ECC command. Codes 01 and 11 give a one-cycle ecc_clr pulse in the cycle after the write. Code 10 holds ecc_rd_sel high while it is stored. Code 00 does neither.
- R8: Window offset 0x05 always reads 0x14.
- R9: Interrupt status sits at window offset 0x06 and takes the written byte. Each data-port write sets its bit 0 and leaves the other bits unchanged.
- R10: From the cycle after any change, irq is high exactly when mask bit 7 (offset 0x07) is set and the AND of mask and status is nonzero.
- R11: Read data is registered and appears on bus_rdata in the cycle after bus_rd. Unassigned offsets in either space read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after bus_rd |
| irq | output | 1 | Interrupt request |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_wp | output | 1 | Write-protect pin level |
| nf_dout | output | 8 | Byte toward the flash |
| nf_din | input | 8 | Byte from the flash |
| nf_wr_stb | output | 1 | Data-write strobe |
| nf_rd_stb | output | 1 | Data-read strobe |
| ecc_clr | output | 1 | One-cycle ECC clear pulse |
| ecc_rd_sel | output | 1 | ECC read mode selected |

## Verification
The assertions assume that bus_wr and bus_rd are never high together. They also assume that the address and write data are valid in every cycle in which either request is high. The stimulus changes inputs only on the falling clock edge, holds each request for exactly one cycle, and then drops it. Access patterns are therefore one clean transaction per cycle, and the assertions rely on that.

// File: rtl/nfh_pkg.sv
package nfh_pkg;
    localparam logic [7:0] CFG_CMD     = 8'h04;
    localparam logic [7:0] CFG_BASE    = 8'h10;
    localparam logic [7:0] OFS_CTRL    = 8'h04;
    localparam logic [7:0] OFS_STAT    = 8'h05;
    localparam logic [7:0] OFS_ISR     = 8'h06;
    localparam logic [7:0] OFS_IMR     = 8'h07;
    localparam logic [7:0] STATUS_WORD = 8'h14;

    localparam logic [1:0] ECC_NONE = 2'b00;
    localparam logic [1:0] ECC_ON   = 2'b01;
    localparam logic [1:0] ECC_RD   = 2'b10;
    localparam logic [1:0] ECC_CLR  = 2'b11;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] isr;
        logic [7:0] imr;
        logic       ecc_clr;
    } core_st_t;
endpackage

// File: rtl/nfh_decode.sv
module nfh_decode #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_en,
    input  logic [ADDR_W-1:0] base,
    output logic              cfg_sel,
    output logic              win_sel,
    output logic [7:0]        off
);
    localparam int PAGE_W = ADDR_W - 8;

    logic [PAGE_W-1:0] page;

    always_comb begin
        page    = addr[ADDR_W-1:8];
        off     = addr[7:0];
        cfg_sel = (page == PAGE_W'(1));
        win_sel = !cfg_sel && win_en && (base[7:0] == 8'h00) &&
                  (page == base[ADDR_W-1:8]);
    end
endmodule

// File: rtl/nfh_cfg.sv
module nfh_cfg
    import nfh_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        off,
    input  logic [7:0]        wdata,
    output logic              win_en,
    output logic [ADDR_W-1:0] base,
    output logic [7:0]        rd_val
);
    localparam int NBYTES = ADDR_W / 8;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rd_val = 8'h00;
        if (wr && off == CFG_CMD)
            st_d.en = wdata[1];
        for (int i = 0; i < NBYTES; i++) begin
            if (wr && off == (CFG_BASE + 8'(i)))
                st_d.base[i*8 +: 8] = wdata;
            if (off == (CFG_BASE + 8'(i)))
                rd_val = st_q.base[i*8 +: 8];
        end
        if (off == CFG_CMD)
            rd_val = {6'b0, st_q.en, 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_en = st_q.en;
    assign base   = st_q.base;
endmodule

// File: rtl/nfh_core.sv
module nfh_core
    import nfh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] off,
    input  logic [7:0] wdata,
    input  logic [7:0] fl_din,
    output logic       fl_wr_stb,
    output logic       fl_rd_stb,
    output logic [7:0] fl_dout,
    output logic       cle,
    output logic       ale,
    output logic       ce_n,
    output logic       wp,
    output logic       ecc_clr,
    output logic       ecc_rd_sel,
    output logic       irq,
    output logic [7:0] rd_val
);
    core_st_t st_d, st_q;
    logic     is_data;

    always_comb begin
        is_data = (off[7:2] == 6'd0);
        st_d    = st_q;
        st_d.ecc_clr = 1'b0;
        if (wr) begin
            if (is_data) begin
                st_d.isr = st_q.isr | 8'h01;
            end else begin
                case (off)
                    OFS_CTRL: begin
                        st_d.ctrl = wdata;
                        case (wdata[6:5])
                            ECC_ON, ECC_CLR: st_d.ecc_clr = 1'b1;
                            default:         st_d.ecc_clr = 1'b0;
                        endcase
                    end
                    OFS_ISR: st_d.isr = wdata;
                    OFS_IMR: st_d.imr = wdata;
                    default: ;
                endcase
            end
        end

        if (is_data) begin
            rd_val = fl_din;
        end else begin
            case (off)
                OFS_CTRL: rd_val = st_q.ctrl;
                OFS_STAT: rd_val = STATUS_WORD;
                OFS_ISR:  rd_val = st_q.isr;
                OFS_IMR:  rd_val = st_q.imr;
                default:  rd_val = 8'h00;
            endcase
        end

        fl_wr_stb  = wr && is_data;
        fl_rd_stb  = rd && is_data;
        fl_dout    = wdata;
        cle        = st_q.ctrl[0];
        ale        = st_q.ctrl[1];
        ce_n       = !st_q.ctrl[4];
        wp         = st_q.ctrl[7];
        ecc_clr    = st_q.ecc_clr;
        ecc_rd_sel = (st_q.ctrl[6:5] == ECC_RD);
        irq        = st_q.imr[7] && ((st_q.imr & st_q.isr) != 8'h00);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/nand_host_if.sv
module nand_host_if #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_ce_n,
    output logic              nf_wp,
    output logic [7:0]        nf_dout,
    input  logic [7:0]        nf_din,
    output logic              nf_wr_stb,
    output logic              nf_rd_stb,
    output logic              ecc_clr,
    output logic              ecc_rd_sel
);
    logic              win_en, cfg_sel, win_sel;
    logic [ADDR_W-1:0] base;
    logic [7:0]        off, cfg_rd, core_rd;
    logic [7:0]        rdata_d, rdata_q;

    nfh_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .win_en(win_en), .base(base),
        .cfg_sel(cfg_sel), .win_sel(win_sel), .off(off)
    );

    nfh_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr && cfg_sel), .off(off),
        .wdata(bus_wdata), .win_en(win_en), .base(base), .rd_val(cfg_rd)
    );

    nfh_core u_core (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr && win_sel),
        .rd(bus_rd && win_sel), .off(off), .wdata(bus_wdata),
        .fl_din(nf_din), .fl_wr_stb(nf_wr_stb), .fl_rd_stb(nf_rd_stb),
        .fl_dout(nf_dout), .cle(nf_cle), .ale(nf_ale), .ce_n(nf_ce_n),
        .wp(nf_wp), .ecc_clr(ecc_clr), .ecc_rd_sel(ecc_rd_sel),
        .irq(irq), .rd_val(core_rd)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd) begin
            if (cfg_sel)      rdata_d = cfg_rd;
            else if (win_sel) rdata_d = core_rd;
            else              rdata_d = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= 8'h00;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/nand_host_if_chk.sv
module nand_host_if_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              win_sel,
    input logic              irq,
    input logic              nf_cle,
    input logic              nf_ale,
    input logic              nf_ce_n,
    input logic              nf_wp,
    input logic              ecc_clr,
    input logic [7:0]        isr
);
    // R6: control write reaches the pins one cycle later
    a_r6_pins_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win_sel && bus_addr[7:0] == 8'h04) |=>
        (nf_cle == $past(bus_wdata[0]) && nf_ale == $past(bus_wdata[1]) &&
         nf_ce_n == !$past(bus_wdata[4]) && nf_wp == $past(bus_wdata[7])));

    // R7: a clear pulse only ever follows a control write with code 01 or 11
    a_r7_ecc_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_clr |-> $past(bus_wr && win_sel && bus_addr[7:0] == 8'h04 &&
                          bus_wdata[5]));

    // R9: data writes raise status bit 0
    a_r9_data_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win_sel && bus_addr[7:2] == 6'd0) |=> isr[0]);

    // R10: clearing the global enable silences the interrupt
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && win_sel && bus_addr[7:0] == 8'h07 && !bus_wdata[7]) |=> !irq);

    // R8, R11: status offset returns its constant one cycle after the read
    a_r8_status_const: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && win_sel && bus_addr[7:0] == 8'h05) |=> bus_rdata == 8'h14);
endmodule

bind nand_host_if nand_host_if_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .win_sel(win_sel), .irq(irq), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_ce_n(nf_ce_n), .nf_wp(nf_wp), .ecc_clr(ecc_clr),
    .isr(u_core.st_q.isr)
);

// File: tb/sim_nand_host_if.sv
`timescale 1ns/1ps
module sim_nand_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0, bus_rdata, nf_dout, nf_din = 8'h00;
    logic        irq, nf_cle, nf_ale, nf_ce_n, nf_wp, nf_wr_stb, nf_rd_stb;
    logic        ecc_clr, ecc_rd_sel;

    int total = 0, bad = 0;
    logic        wstb_seen, rstb_seen, ecc_seen;
    logic [7:0]  dout_seen, rd_got;

    localparam logic [31:0] WIN  = 32'h4000_0A00;
    localparam logic [31:0] CFGA = 32'h0000_0100;

    always #4 clk = ~clk;

    nand_host_if u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n),
        .nf_wp(nf_wp), .nf_dout(nf_dout), .nf_din(nf_din),
        .nf_wr_stb(nf_wr_stb), .nf_rd_stb(nf_rd_stb),
        .ecc_clr(ecc_clr), .ecc_rd_sel(ecc_rd_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 wstb_seen = nf_wr_stb; dout_seen = nf_dout;
        @(negedge clk);
        bus_wr = 1'b0;
        ecc_seen = ecc_clr;
    endtask

    task automatic rd(input logic [31:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 rstb_seen = nf_rd_stb;
        @(negedge clk);
        bus_rd = 1'b0;
        rd_got = bus_rdata;
    endtask

    task automatic t_reset;
        chk("R1 ce_n", nf_ce_n, 1); chk("R1 cle", nf_cle, 0);
        chk("R1 wp", nf_wp, 0);     chk("R1 irq", irq, 0);
        chk("R1 ecc_clr", ecc_clr, 0);
        rd(CFGA + 32'h04); chk("R1 enable", rd_got, 8'h00);
        rd(CFGA + 32'h10); chk("R1 base", rd_got, 8'h00);
        rd(WIN + 32'h05);  chk("R4 disabled window", rd_got, 8'h00);
    endtask

    task automatic t_cfg;
        wr(CFGA + 32'h10, 8'h00); wr(CFGA + 32'h11, 8'h0A);
        wr(CFGA + 32'h12, 8'h00); wr(CFGA + 32'h13, 8'h40);
        rd(CFGA + 32'h11); chk("R3 byte1", rd_got, 8'h0A);
        rd(CFGA + 32'h13); chk("R3 byte3", rd_got, 8'h40);
        wr(CFGA + 32'h04, 8'h02);
        rd(CFGA + 32'h04); chk("R2 enable on", rd_got, 8'h02);
        wr(CFGA + 32'h04, 8'hFD);
        rd(CFGA + 32'h04); chk("R2 enable off", rd_got, 8'h00);
        wr(CFGA + 32'h04, 8'h02);
    endtask

    task automatic t_window;
        rd(WIN + 32'h05); chk("R8 status", rd_got, 8'h14);
        rd(WIN + 32'h105); chk("R4 other page", rd_got, 8'h00);
        wr(WIN + 32'h104, 8'h11);
        rd(WIN + 32'h04); chk("R4 ignored write", rd_got, 8'h00);
        chk("R4 ce_n untouched", nf_ce_n, 1);
    endtask

    task automatic t_ctrl;
        wr(WIN + 32'h04, 8'h93);
        chk("R6 cle", nf_cle, 1); chk("R6 ale", nf_ale, 1);
        chk("R6 ce_n", nf_ce_n, 0); chk("R6 wp", nf_wp, 1);
        rd(WIN + 32'h04); chk("R6 readback", rd_got, 8'h93);
        wr(WIN + 32'h04, 8'h00);
        chk("R6 ce_n released", nf_ce_n, 1); chk("R6 wp off", nf_wp, 0);
    endtask

    task automatic t_ecc;
        wr(WIN + 32'h04, 8'h20); chk("R7 code01 pulse", ecc_seen, 1);
        @(negedge clk); chk("R7 pulse one cycle", ecc_clr, 0);
        chk("R7 code01 no rdsel", ecc_rd_sel, 0);
        wr(WIN + 32'h04, 8'h60); chk("R7 code11 pulse", ecc_seen, 1);
        wr(WIN + 32'h04, 8'h40); chk("R7 code10 no pulse", ecc_seen, 0);
        chk("R7 code10 rdsel", ecc_rd_sel, 1);
        wr(WIN + 32'h04, 8'h00); chk("R7 code00 no pulse", ecc_seen, 0);
        chk("R7 code00 rdsel", ecc_rd_sel, 0);
    endtask

    task automatic t_data;
        nf_din = 8'h5A;
        rd(WIN + 32'h02);
        chk("R5 read strobe", rstb_seen, 1); chk("R5 read data", rd_got, 8'h5A);
        wr(WIN + 32'h03, 8'hC3);
        chk("R5 write strobe", wstb_seen, 1); chk("R5 dout", dout_seen, 8'hC3);
        rd(WIN + 32'h06); chk("R9 data sets bit0", rd_got, 8'h01);
        wr(WIN + 32'h06, 8'h40); wr(WIN + 32'h00, 8'h00);
        rd(WIN + 32'h06); chk("R9 other bits kept", rd_got, 8'h41);
        wr(WIN + 32'h06, 8'h00);
        rd(WIN + 32'h06); chk("R9 isr written", rd_got, 8'h00);
    endtask

    task automatic t_irq;
        wr(WIN + 32'h07, 8'h01); wr(WIN + 32'h01, 8'hAA);
        chk("R10 no global enable", irq, 0);
        wr(WIN + 32'h07, 8'h81); chk("R10 fires", irq, 1);
        rd(WIN + 32'h07); chk("R10 mask readback", rd_got, 8'h81);
        wr(WIN + 32'h06, 8'h00); chk("R10 status cleared", irq, 0);
        wr(WIN + 32'h06, 8'h02); chk("R10 unmasked bit", irq, 0);
        wr(WIN + 32'h07, 8'h83); chk("R10 bit1 masked in", irq, 1);
        wr(WIN + 32'h07, 8'h03); chk("R10 enable dropped", irq, 0);
    endtask

    task automatic t_unmapped;
        rd(WIN + 32'h08); chk("R11 window hole", rd_got, 8'h00);
        rd(CFGA + 32'h20); chk("R11 cfg hole", rd_got, 8'h00);
        wr(CFGA + 32'h10, 8'h01);
        rd(WIN + 32'h05); chk("R4 base low byte set", rd_got, 8'h00);
        wr(CFGA + 32'h10, 8'h00);
        wr(CFGA + 32'h11, 8'h01); wr(CFGA + 32'h13, 8'h00);
        rd(CFGA + 32'h05); chk("R4 cfg priority", rd_got, 8'h00);
    endtask

    initial begin
        #(8 * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_cfg; t_window; t_ctrl; t_ecc; t_data; t_irq; t_unmapped;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule